// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block feeds a configuration bitstream to a target FPGA over a two-wire serial link: a configuration clock and a data line. Software stages the stream word by word. It first sets a small control word that gives the valid-byte count and an end-of-stream marker. It then writes the 32-bit payload, and that write commits one entry to an internal FIFO held in block RAM. A serializer drains the FIFO and shifts every valid byte onto the data line. The serial clock comes from a programmable half-rate divider.

After the entry that carries the end-of-stream marker has been shifted out, the serializer parks the clock low and raises a completion flag. An exit command ends the session. It empties the FIFO, clears the sticky flags and returns both pins to the passive low level. A packed status word reports the FIFO fill level and its flags to the surrounding register logic.

Top module: `bitstream_loader`

## Requirements
- R1: After reset, `cfg_clk` and `cfg_data` are 0, `load_done` is 0 and `fifo_status` reads 32'h0002_0000 (empty, level 0).
- R2: While shifting, each half period of `cfg_clk` lasts `clk_div`+1 system cycles, so consecutive rising edges within an entry are 2*(`clk_div`+1) cycles apart.
- R3: The 2-bit size field of an entry selects how many bytes of its 32-bit word are sent: code n sends n+1 bytes (0 sends one byte, 3 sends all four), that is 8*(n+1) clock pulses.
- R4: Bytes go out starting at bits [7:0] and moving up, each byte most significant bit first. `cfg_data` changes only while `cfg_clk` is low, so it is stable across every rising edge.
- R5: A pulse on `data_wr` pushes `data_in` together with the size and last values most recently captured by `ctrl_wr`. When `ctrl_wr` and `data_wr` occur in the same cycle, the new control values apply to that push.
- R6: Once an entry with its last flag set has been fully shifted, `cfg_clk` stays low and `load_done` is 1. Both hold until an exit, and no further entry is popped or sent in the meantime.
- R7: `fifo_status` carries the fill level in bits [15:0], the full flag at bit 16, the empty flag at bit 17 and the overflow flag at bit 18. All other bits are 0.
- R8: A `data_wr` while the FIFO is full is discarded, leaving the level unchanged, and it sets the overflow flag, which stays set until an exit.
- R9: A pulse on `exit_cmd` empties the FIFO, clears `load_done` and the overflow flag, and drives `cfg_clk` and `cfg_data` low on the next cycle. A `data_wr` in the same cycle is discarded.
- R10: A push and a pop in the same cycle leave the FIFO level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Capture `ctrl_size` and `ctrl_last` |
| ctrl_size | input | 2 | Valid-byte code for following entries (n means n+1 bytes) |
| ctrl_last | input | 1 | End-of-stream marker for following entries |
| data_wr | input | 1 | Push `data_in` with the current control values |
| data_in | input | 32 | Bitstream word |
| exit_cmd | input | 1 | End the loading session and return to passive |
| clk_div | input | DIV_W | Divider setting: half period is `clk_div`+1 cycles |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| load_done | output | 1 | Last entry fully sent |
| fifo_status | output | 32 | Level [15:0], full 16, empty 17, overflow 18 |

## Verification
Two things can fall in the same cycle. The first is a software push and a serializer pop. The bench provokes it by issuing two back-to-back data writes into an idle, empty FIFO: the second write lands on the edge where the serializer pops the first entry, and the level read immediately afterwards must still be 1. The second is an exit command and a data write in the same cycle. The bench judges it after a full FIFO has overflowed: the status must come back empty with the overflow flag cleared, proving the write was discarded.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam int WORD_W  = 32;
  localparam int SIZE_W  = 2;
  localparam int ENTRY_W = WORD_W + SIZE_W + 1;

  typedef struct packed {
    logic              last;
    logic [SIZE_W-1:0] size;
    logic [WORD_W-1:0] data;
  } bsl_entry_t;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_FETCH = 2'd1,
    SH_SHIFT = 2'd2,
    SH_HALT  = 2'd3
  } sh_state_t;
endpackage

// File: rtl/bsl_fifo.sv
module bsl_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 35,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;
  logic [CNT_W-1:0] nxt_level;

  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    nxt_level = level;
    if (push_ok && !pop_ok) nxt_level = level + CNT_W'(1);
    if (pop_ok && !push_ok) nxt_level = level - CNT_W'(1);
  end

  // storage and read port without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
    if (pop_ok)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      level <= nxt_level;
      full  <= (nxt_level == CNT_W'(DEPTH));
      empty <= (nxt_level == '0);
    end
  end
endmodule

// File: rtl/bsl_clkdiv.sv
module bsl_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/bsl_shifter.sv
module bsl_shifter
  import bsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       fifo_empty,
  input  bsl_entry_t fifo_rdata,
  input  logic       tick,
  output logic       fifo_pop,
  output logic       div_run,
  output logic       cfg_clk,
  output logic       cfg_data,
  output logic       done
);
  sh_state_t         state;
  logic [WORD_W-1:0] word_q;
  logic [SIZE_W-1:0] nbytes_q;
  logic [SIZE_W-1:0] byte_q;
  logic [2:0]        bit_q;
  logic              last_q;
  logic [SIZE_W-1:0] nxt_byte;
  logic [2:0]        nxt_bit;
  logic              word_end;

  assign fifo_pop = (state == SH_IDLE) && !fifo_empty && !abort;
  assign div_run  = (state == SH_SHIFT);
  assign word_end = (bit_q == 3'd0) && (byte_q == nbytes_q);

  always_comb begin
    if (bit_q == 3'd0) begin
      nxt_byte = byte_q + SIZE_W'(1);
      nxt_bit  = 3'd7;
    end else begin
      nxt_byte = byte_q;
      nxt_bit  = bit_q - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state    <= SH_IDLE;
      cfg_clk  <= 1'b0;
      cfg_data <= 1'b0;
      done     <= 1'b0;
      word_q   <= '0;
      nbytes_q <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
      last_q   <= 1'b0;
    end else begin
      unique case (state)
        SH_IDLE: begin
          if (fifo_pop) state <= SH_FETCH;
        end
        SH_FETCH: begin
          word_q   <= fifo_rdata.data;
          nbytes_q <= fifo_rdata.size;
          last_q   <= fifo_rdata.last;
          byte_q   <= '0;
          bit_q    <= 3'd7;
          cfg_data <= fifo_rdata.data[7];
          state    <= SH_SHIFT;
        end
        SH_SHIFT: begin
          if (tick) begin
            if (!cfg_clk) begin
              cfg_clk <= 1'b1;
            end else begin
              cfg_clk <= 1'b0;
              if (word_end) begin
                if (last_q) begin
                  state    <= SH_HALT;
                  done     <= 1'b1;
                  cfg_data <= 1'b0;
                end else begin
                  state <= SH_IDLE;
                end
              end else begin
                byte_q   <= nxt_byte;
                bit_q    <= nxt_bit;
                cfg_data <= word_q[{nxt_byte, nxt_bit}];
              end
            end
          end
        end
        SH_HALT: begin
          state <= SH_HALT;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitstream_loader.sv
module bitstream_loader
  import bsl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_size,
  input  logic              ctrl_last,
  input  logic              data_wr,
  input  logic [31:0]       data_in,
  input  logic              exit_cmd,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              cfg_clk,
  output logic              cfg_data,
  output logic              load_done,
  output logic [31:0]       fifo_status
);
  localparam int LVL_BITS = 16;

  logic [SIZE_W-1:0] size_q;
  logic              last_q;
  logic              ovf_q;
  bsl_entry_t        wr_entry, rd_entry;
  logic              f_full, f_empty, f_pop, push;
  logic [CNT_W-1:0]  f_level;
  logic              div_run, div_tick;

  // same-cycle control write is forwarded into the push
  always_comb begin
    wr_entry.data = data_in;
    wr_entry.size = ctrl_wr ? ctrl_size : size_q;
    wr_entry.last = ctrl_wr ? ctrl_last : last_q;
  end

  assign push = data_wr && !exit_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      last_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        size_q <= ctrl_size;
        last_q <= ctrl_last;
      end
      if (exit_cmd)                 ovf_q <= 1'b0;
      else if (data_wr && f_full)   ovf_q <= 1'b1;
    end
  end

  bsl_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .flush (exit_cmd),
    .push  (push),
    .wdata (wr_entry),
    .pop   (f_pop),
    .rdata (rd_entry),
    .level (f_level),
    .full  (f_full),
    .empty (f_empty)
  );

  bsl_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .run  (div_run),
    .div  (clk_div),
    .tick (div_tick)
  );

  bsl_shifter sh_i (
    .clk        (clk),
    .rst        (rst),
    .abort      (exit_cmd),
    .fifo_empty (f_empty),
    .fifo_rdata (rd_entry),
    .tick       (div_tick),
    .fifo_pop   (f_pop),
    .div_run    (div_run),
    .cfg_clk    (cfg_clk),
    .cfg_data   (cfg_data),
    .done       (load_done)
  );

  assign fifo_status = {13'd0, ovf_q, f_empty, f_full, LVL_BITS'(f_level)};
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker (
  input logic        clk,
  input logic        rst,
  input logic        data_wr,
  input logic        exit_cmd,
  input logic        cfg_clk,
  input logic        cfg_data,
  input logic        load_done,
  input logic [31:0] fifo_status
);
  logic [15:0] lvl;
  assign lvl = fifo_status[15:0];

  a_r7_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(fifo_status[16] && fifo_status[17]));

  a_r7_zero_bits: assert property (@(posedge clk) disable iff (rst)
    fifo_status[31:19] == 13'd0);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (fifo_status[18] && !exit_cmd) |=> fifo_status[18]);

  a_r8_full_write_flags: assert property (@(posedge clk) disable iff (rst)
    (fifo_status[16] && data_wr && !exit_cmd) |=> fifo_status[18]);

  a_r9_exit_clears: assert property (@(posedge clk) disable iff (rst)
    exit_cmd |=> (!cfg_clk && !cfg_data && !load_done && fifo_status[17] && !fifo_status[18]));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
    (load_done && !exit_cmd) |=> (load_done && !cfg_clk));

  a_r4_data_on_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_data) |-> !cfg_clk);

  a_r10_level_step: assert property (@(posedge clk) disable iff (rst)
    !exit_cmd |=> (lvl == $past(lvl) || lvl == $past(lvl) + 16'd1 || lvl + 16'd1 == $past(lvl)));
endmodule

bind bitstream_loader bsl_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .data_wr     (data_wr),
  .exit_cmd    (exit_cmd),
  .cfg_clk     (cfg_clk),
  .cfg_data    (cfg_data),
  .load_done   (load_done),
  .fifo_status (fifo_status)
);

// File: tb/bitstream_loader_tb_top.sv
module bitstream_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DIV_W      = 8;
  localparam int WD_LIMIT   = 100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ctrl_wr = 1'b0;
  logic [1:0]       ctrl_size = '0;
  logic             ctrl_last = 1'b0;
  logic             data_wr = 1'b0;
  logic [31:0]      data_in = '0;
  logic             exit_cmd = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic             cfg_clk, cfg_data, load_done;
  logic [31:0]      fifo_status;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic cap_bits [512];
  int   cap_t    [512];
  int   ncap = 0;
  logic prev_clk = 1'b0;

  logic exp_bits [512];
  int   nexp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_loader #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dut_i (
    .clk (clk), .rst (rst), .ctrl_wr (ctrl_wr), .ctrl_size (ctrl_size),
    .ctrl_last (ctrl_last), .data_wr (data_wr), .data_in (data_in),
    .exit_cmd (exit_cmd), .clk_div (clk_div), .cfg_clk (cfg_clk),
    .cfg_data (cfg_data), .load_done (load_done), .fifo_status (fifo_status)
  );

  // monitor: record data at each rising serial clock edge
  always @(negedge clk) begin
    if (!prev_clk && cfg_clk && ncap < 512) begin
      cap_bits[ncap] = cfg_data;
      cap_t[ncap]    = cyc;
      ncap = ncap + 1;
    end
    prev_clk = cfg_clk;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_exp(input logic [31:0] d, input int sz);
    for (int b = 0; b <= sz; b++)
      for (int k = 7; k >= 0; k--) begin
        exp_bits[nexp] = d[b*8 + k];
        nexp = nexp + 1;
      end
  endtask

  task automatic wr_ctrl(input logic [1:0] sz, input logic last);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_size = sz; ctrl_last = last;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] d);
    @(negedge clk);
    data_wr = 1'b1; data_in = d;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk);
    exit_cmd = 1'b1;
    @(negedge clk);
    exit_cmd = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !load_done; i++) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req, input int base);
    int bad;
    bad = -1;
    for (int i = 0; i < nexp; i++)
      if (bad < 0 && cap_bits[base + i] !== exp_bits[i]) bad = i;
    check({req, " bit count"}, 32'(ncap - base), 32'(nexp));
    checks = checks + 1;
    if (bad >= 0) begin
      errors = errors + 1;
      $display("FAIL %s: bit %0d actual=%b expected=%b", req, bad, cap_bits[base + bad], exp_bits[bad]);
    end
  endtask

  task automatic t_reset();
    check("R1 status", fifo_status, 32'h0002_0000);
    check("R1 pins", {30'd0, cfg_clk, cfg_data}, 32'd0);
    check("R1 done", {31'd0, load_done}, 32'd0);
  endtask

  task automatic t_stream();
    int base;
    clk_div = 8'd1;
    base = ncap; nexp = 0;
    wr_ctrl(2'd0, 1'b0);
    wr_data(32'h0000_00A5); add_exp(32'h0000_00A5, 0);
    wr_data(32'h0000_003C); add_exp(32'h0000_003C, 0);  // R5 reuse of control
    wr_ctrl(2'd1, 1'b0);
    wr_data(32'h0000_1234); add_exp(32'h0000_1234, 1);
    wr_ctrl(2'd2, 1'b0);
    wr_data(32'h00C0_FFEE); add_exp(32'h00C0_FFEE, 2);
    wr_ctrl(2'd3, 1'b1);
    wr_data(32'hDEAD_BEEF); add_exp(32'hDEAD_BEEF, 3);
    wait_done(2000);
    cmp_stream("R3 R4 R5 stream", base);
    check("R2 spacing div1 first", 32'(cap_t[base+1] - cap_t[base]), 32'd4);
    check("R2 spacing div1 late", 32'(cap_t[base+7] - cap_t[base+6]), 32'd4);
    check("R6 done set", {31'd0, load_done}, 32'd1);
    // R6: further entries stay queued, no clock activity
    base = ncap;
    wr_data(32'h0000_00FF);
    repeat (60) @(negedge clk);
    check("R6 no new pulses", 32'(ncap - base), 32'd0);
    check("R6 entry held", fifo_status, 32'h0000_0001);
    check("R6 clock low", {31'd0, cfg_clk}, 32'd0);
    do_exit();
    check("R9 exit status", fifo_status, 32'h0002_0000);
    check("R9 exit done", {31'd0, load_done}, 32'd0);
  endtask

  task automatic t_div3();
    int base;
    clk_div = 8'd3;
    base = ncap; nexp = 0;
    wr_ctrl(2'd0, 1'b1);
    wr_data(32'h0000_0096); add_exp(32'h0000_0096, 0);
    wait_done(2000);
    cmp_stream("R2 R4 div3 stream", base);
    check("R2 spacing div3", 32'(cap_t[base+4] - cap_t[base+3]), 32'd8);
    do_exit();
  endtask

  task automatic t_push_pop();
    clk_div = 8'd40;
    wr_ctrl(2'd0, 1'b0);
    @(negedge clk);
    data_wr = 1'b1; data_in = 32'h11;
    @(negedge clk);
    data_in = 32'h22;
    @(negedge clk);
    data_wr = 1'b0;
    check("R10 level after push+pop", fifo_status, 32'h0000_0001);
    do_exit();
    check("R9 exit mid-shift", {30'd0, cfg_clk, cfg_data}, 32'd0);
  endtask

  task automatic t_overflow();
    clk_div = 8'd0;
    wr_ctrl(2'd0, 1'b1);
    wr_data(32'h81);
    wait_done(500);
    wr_ctrl(2'd0, 1'b0);
    for (int i = 0; i < DEPTH; i++) wr_data(32'(i));
    check("R7 full status", fifo_status, 32'h0001_0010);
    wr_data(32'hBAD);
    check("R8 overflow", fifo_status, 32'h0005_0010);
    @(negedge clk);
    exit_cmd = 1'b1; data_wr = 1'b1; data_in = 32'h77;
    @(negedge clk);
    exit_cmd = 1'b0; data_wr = 1'b0;
    check("R9 exit drops write", fifo_status, 32'h0002_0000);
    check("R9 exit clears done", {31'd0, load_done}, 32'd0);
  endtask

  task automatic t_same_cycle();
    int base;
    clk_div = 8'd2;
    base = ncap; nexp = 0;
    wr_ctrl(2'd0, 1'b0);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_size = 2'd1; ctrl_last = 1'b1;
    data_wr = 1'b1; data_in = 32'h0000_5AC3;
    @(negedge clk);
    ctrl_wr = 1'b0; data_wr = 1'b0;
    add_exp(32'h0000_5AC3, 1);
    wait_done(2000);
    cmp_stream("R5 same-cycle control", base);
    check("R6 done after same-cycle", {31'd0, load_done}, 32'd1);
    do_exit();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stream();
    t_div3();
    t_push_pop();
    t_overflow();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule